// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from the command, buffer and data engines of a card host controller and holds them in a 32-bit sticky status register. A mask register with the same bit layout decides which of the held bits may reach the two interrupt lines. One line is for error conditions and the other is for normal progress events. Software reads both registers back through plain ports.

To clear status bits, software writes zeros to them; bits written as one are left as they are. A separate single-cycle input clears the whole group of automatic stop-command completion bits, together with the buffer-read-end bit, in one step. An error summary output reports whether any error condition is held, whatever the mask.

All inputs are level or pulse signals sampled on the rising clock edge. The unit has no streaming data path, so it has no valid/ready interface and no back-pressure.

Top module: `irq_status_unit`

## Requirements
- R1: While `rst_n` is low, `status_o` and `mask_o` read zero, which masks everything, and `irq_err_o`, `irq_evt_o` and `err_pending_o` are low.
- R2: A high bit of `event_i` at a defined position sets that bit of `status_o` from the next clock edge. The bit then stays set until it is cleared.
- R3: A cycle with `sts_wr_i` high clears every status bit whose `sts_wdata_i` bit is 0 and leaves every bit written as 1 unchanged. A write never sets a bit.
- R4: If an event and a clear (by write or by `stop_clr_i`) hit the same bit in one cycle, the event wins and the bit is set after the edge.
- R5: A cycle with `mask_wr_i` high loads `mask_wdata_i` into the mask at the defined positions, effective from the next edge. A mask bit of 1 enables that interrupt.
- R6: `irq_err_o` is high exactly while some error-group status bit (15, 14, 11, 10, 9, 8, 5, 4, 3, 2, 1, 0) is set and its mask bit is 1.
- R7: `irq_evt_o` is high exactly while some normal-group status bit (29, 26, 25, 24, 23, 22, 21, 20, 19, 17, 16) is set and its mask bit is 1.
- R8: Status bits latch while masked. Unmasking a pending bit raises its interrupt line from the edge that loads the mask.
- R9: A cycle with `stop_clr_i` high clears status bits 26, 25, 24 and 22 and leaves all other bits unchanged.
- R10: The reserved positions (31, 30, 28, 27, 18, 13, 12, 7, 6) always read 0 in both `status_o` and `mask_o`. Events and writes at those positions have no effect.
- R11: `err_pending_o` is high exactly while any error-group status bit is set, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | 32 | Event pulses, one per status position |
| sts_wr_i | input | 1 | Status write strobe (write-zero-to-clear) |
| sts_wdata_i | input | 32 | Status write data |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 32 | Mask write data |
| stop_clr_i | input | 1 | Clears the automatic stop-command group and buffer-read-end |
| status_o | output | 32 | Status register contents |
| mask_o | output | 32 | Mask register contents |
| irq_err_o | output | 1 | Error interrupt line |
| irq_evt_o | output | 1 | Normal-event interrupt line |
| err_pending_o | output | 1 | Any error status bit set, unmasked or not |

## Verification
The bench uses the default parameters: a 32-bit register, the standard normal-event and error maps, and the default stop-clear group. With these values all 32 positions can be reached, including the nine reserved ones. It drives every position on its own, collisions of an event with both kinds of clear, and a pending bit that is unmasked later. It then runs a long stretch of sparse random events, writes and mask changes. Because the group maps are parameters of the top, the reserved-position checks and the split between the two lines are tested on exactly the layout that the requirements state.

// File: rtl/ismu_pkg.sv
package ismu_pkg;
  localparam int unsigned REG_W = 32;

  // normal progress events: 29,26,25,24,23,22,21,20,19,17,16
  localparam logic [REG_W-1:0] EVT_MAP_DEF  = 32'h27FB_0000;
  // error conditions: 15,14,11,10,9,8,5..0
  localparam logic [REG_W-1:0] ERR_MAP_DEF  = 32'h0000_CF3F;
  // group cleared by the stop-clear strobe: 26,25,24,22
  localparam logic [REG_W-1:0] STOP_MAP_DEF = 32'h0740_0000;

  typedef enum logic [1:0] {
    BIT_RESERVED = 2'd0,
    BIT_NORMAL   = 2'd1,
    BIT_ERROR    = 2'd2
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input logic evt, input logic err);
    if (err)      return BIT_ERROR;
    else if (evt) return BIT_NORMAL;
    else          return BIT_RESERVED;
  endfunction
endpackage

// File: rtl/ismu_stat_cell.sv
module ismu_stat_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // event has priority over any clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/ismu_mask_reg.sv
module ismu_mask_reg #(
  parameter int unsigned       W     = 32,
  parameter logic [W-1:0]      VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & VALID;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ismu_irq_reduce.sv
module ismu_irq_reduce #(
  parameter int unsigned  W       = 32,
  parameter logic [W-1:0] EVT_MAP = '0,
  parameter logic [W-1:0] ERR_MAP = '0
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_err_o,
  output logic         irq_evt_o,
  output logic         err_any_o
);
  logic [W-1:0] live;

  always_comb begin
    live      = status_i & mask_i;
    irq_err_o = |(live & ERR_MAP);
    irq_evt_o = |(live & EVT_MAP);
    err_any_o = |(status_i & ERR_MAP);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import ismu_pkg::*;
#(
  parameter int unsigned      DATA_W   = REG_W,
  parameter logic [DATA_W-1:0] EVT_MAP  = EVT_MAP_DEF,
  parameter logic [DATA_W-1:0] ERR_MAP  = ERR_MAP_DEF,
  parameter logic [DATA_W-1:0] STOP_MAP = STOP_MAP_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] event_i,
  input  logic              sts_wr_i,
  input  logic [DATA_W-1:0] sts_wdata_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  input  logic              stop_clr_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_err_o,
  output logic              irq_evt_o,
  output logic              err_pending_o
);
  localparam logic [DATA_W-1:0] VALID_MAP = EVT_MAP | ERR_MAP;

  logic [DATA_W-1:0] sts_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam bit_kind_e KIND = kind_of(EVT_MAP[b], ERR_MAP[b]);
    if (KIND != BIT_RESERVED) begin : g_cell
      logic clr;
      assign clr = (sts_wr_i & ~sts_wdata_i[b]) | (stop_clr_i & STOP_MAP[b]);
      ismu_stat_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (event_i[b]),
        .clr_i (clr),
        .q_o   (sts_q[b])
      );
    end else begin : g_rsvd
      assign sts_q[b] = 1'b0;
    end
  end

  ismu_mask_reg #(.W(DATA_W), .VALID(VALID_MAP)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_o)
  );

  ismu_irq_reduce #(.W(DATA_W), .EVT_MAP(EVT_MAP), .ERR_MAP(ERR_MAP)) u_reduce (
    .status_i  (sts_q),
    .mask_i    (mask_o),
    .irq_err_o (irq_err_o),
    .irq_evt_o (irq_evt_o),
    .err_any_o (err_pending_o)
  );

  assign status_o = sts_q;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] EVT_MAP  = '0,
  parameter logic [DATA_W-1:0] ERR_MAP  = '0,
  parameter logic [DATA_W-1:0] STOP_MAP = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] event_i,
  input logic              sts_wr_i,
  input logic [DATA_W-1:0] sts_wdata_i,
  input logic              mask_wr_i,
  input logic [DATA_W-1:0] mask_wdata_i,
  input logic              stop_clr_i,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] mask_o,
  input logic              irq_err_o,
  input logic              irq_evt_o,
  input logic              err_pending_o
);
  localparam logic [DATA_W-1:0] VALID_MAP = EVT_MAP | ERR_MAP;

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    |(event_i & VALID_MAP) |=> ((status_o & $past(event_i & VALID_MAP)) == $past(event_i & VALID_MAP)));

  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_i && event_i == '0 && !stop_clr_i) |=> status_o == ($past(status_o) & $past(sts_wdata_i)));

  a_r2_sticky_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr_i && event_i == '0 && !stop_clr_i) |=> $stable(status_o));

  a_r9_stop_group: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_clr_i && !sts_wr_i && event_i == '0) |=> status_o == ($past(status_o) & ~STOP_MAP));

  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> mask_o == ($past(mask_wdata_i) & VALID_MAP));

  a_r6_err_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o == |(status_o & mask_o & ERR_MAP));

  a_r7_evt_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt_o == |(status_o & mask_o & EVT_MAP));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o | mask_o) & ~VALID_MAP) == '0);

  a_r11_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
    err_pending_o == |(status_o & ERR_MAP));
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .DATA_W(DATA_W), .EVT_MAP(EVT_MAP), .ERR_MAP(ERR_MAP), .STOP_MAP(STOP_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .event_i(event_i), .sts_wr_i(sts_wr_i),
  .sts_wdata_i(sts_wdata_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
  .stop_clr_i(stop_clr_i), .status_o(status_o), .mask_o(mask_o),
  .irq_err_o(irq_err_o), .irq_evt_o(irq_evt_o), .err_pending_o(err_pending_o)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam logic [31:0] EVT  = 32'h27FB_0000;
  localparam logic [31:0] ERR  = 32'h0000_CF3F;
  localparam logic [31:0] STOP = 32'h0740_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] event_i = '0, sts_wdata_i = '0, mask_wdata_i = '0;
  logic        sts_wr_i = 1'b0, mask_wr_i = 1'b0, stop_clr_i = 1'b0;
  logic [31:0] status_o, mask_o;
  logic        irq_err_o, irq_evt_o, err_pending_o;

  int checks = 0, fails = 0;
  string tag = "R1 reset";
  logic [31:0] m_sts = '0, m_mask = '0;

  always #2 clk = ~clk;   // 250 MHz

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .sts_wr_i(sts_wr_i),
    .sts_wdata_i(sts_wdata_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .stop_clr_i(stop_clr_i), .status_o(status_o), .mask_o(mask_o),
    .irq_err_o(irq_err_o), .irq_evt_o(irq_evt_o), .err_pending_o(err_pending_o)
  );

  // behavioural reference: event beats any clear, reserved bits dropped
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts  = '0;
      m_mask = '0;
    end else begin
      logic [31:0] nx;
      nx = m_sts;
      if (sts_wr_i)   nx = nx & sts_wdata_i;
      if (stop_clr_i) nx = nx & ~STOP;
      nx = (nx | event_i) & (EVT | ERR);
      m_sts = nx;
      if (mask_wr_i) m_mask = mask_wdata_i & (EVT | ERR);
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] a, e;
    a = {29'd0, irq_err_o, irq_evt_o, err_pending_o};
    e = {29'd0, |(m_sts & m_mask & ERR), |(m_sts & m_mask & EVT), |(m_sts & ERR)};
    check({tag, " status"}, status_o, m_sts);
    check({tag, " mask"}, mask_o, m_mask);
    check({tag, " lines R6 R7 R11"}, a, e);
  end

  task automatic step(logic [31:0] ev, logic sw, logic [31:0] sd,
                      logic mw, logic [31:0] md, logic sc);
    event_i = ev; sts_wr_i = sw; sts_wdata_i = sd;
    mask_wr_i = mw; mask_wdata_i = md; stop_clr_i = sc;
    @(negedge clk);
    event_i = '0; sts_wr_i = 0; mask_wr_i = 0; stop_clr_i = 0;
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", status_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R2 R10 single events";
    for (int b = 0; b < 32; b++) step(32'h1 << b, 0, 0, 0, 0, 0);
    check("R10 reserved status zero", status_o & ~(EVT | ERR), 32'h0);
    check("R8 latched while masked", status_o, EVT | ERR);

    tag = "R8 unmask pending";
    step(0, 0, 0, 1, ERR, 0);
    check("R8 err line after unmask", {31'd0, irq_err_o}, 32'd1);
    step(0, 0, 0, 1, 32'hFFFF_FFFF, 0);
    check("R10 reserved mask zero", mask_o, EVT | ERR);

    tag = "R9 stop group clear";
    step(0, 0, 0, 0, 0, 1);
    check("R9 group gone", status_o, (EVT | ERR) & ~STOP);

    tag = "R3 write zero clears";
    step(0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    check("R3 ones keep", status_o, (EVT | ERR) & ~STOP);
    step(0, 1, ~ERR, 0, 0, 0);
    check("R6 R11 errors cleared", {30'd0, irq_err_o, err_pending_o}, 32'd0);
    step(0, 1, 32'h0, 0, 0, 0);
    check("R3 all cleared", status_o, 32'h0);

    tag = "R4 event beats clear";
    step(32'h0010_0001, 1, 32'h0, 0, 0, 0);
    check("R4 write collision", status_o, 32'h0010_0001);
    step(32'h0100_0000, 0, 0, 0, 0, 1);
    check("R4 stop collision", status_o & STOP, 32'h0100_0000);

    tag = "R5 R6 R7 mask patterns";
    step(0, 0, 0, 1, EVT, 0);
    check("R7 evt line", {30'd0, irq_evt_o, irq_err_o}, 32'd2);
    step(0, 0, 0, 1, 32'h0, 0);
    check("R5 all masked", {30'd0, irq_evt_o, irq_err_o}, 32'd0);
    check("R11 summary ignores mask", {31'd0, err_pending_o}, 32'd1);

    tag = "R2 R3 R4 R5 R9 random";
    for (int i = 0; i < 3000; i++) begin
      step($urandom & $urandom & $urandom & $urandom,
           ($urandom % 4) == 0, ~($urandom & $urandom & $urandom),
           ($urandom % 8) == 0, $urandom, ($urandom % 16) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule